// File: doc/BRIEF.md
# Linked-Store Reservation Monitor

This block lets several requesters that share one small memory build atomic read-modify-write sequences out of two separate accesses. A requester first issues a linked load. The memory word comes back and the block notes, for that requester, which word it read. Later the same requester issues a conditional store to that word. The store only takes effect if no other requester has written the word in the meantime. The response tells the requester whether it won, so a software loop can retry until the pair behaves as if it were indivisible.

All requesters share one request channel. A request carries the requester number, an operation code, a word address and write data. Every request gets a registered response one cycle later. For reads, the response carries the data that was in memory before the request. For conditional stores, it carries a success flag. Each requester owns exactly one reservation entry, which holds a valid bit and a word address.

Top module: `linked_store_monitor`

## Requirements
- R1: After reset, every memory word reads as zero, no reservation is valid, and `rspValid` is low.
- R2: The op code on `reqOp` is 0 for a plain load, 1 for a plain store, 2 for a linked load and 3 for a conditional store. Every accepted request raises `rspValid` on the following cycle. For op 0 and op 2, `rspData` then holds the word that was stored before the request. For op 1 and op 3, `rspData` is zero.
- R3: A plain store always writes `reqWdata` to the addressed word.
- R4: A conditional store from a requester whose reservation is valid for the same address writes the word and returns `rspScOk` = 1.
- R5: A conditional store that fails returns `rspScOk` = 0 and leaves memory unchanged.
- R6: A plain store from one requester to an address clears every other requester's reservation on that address.
- R7: A successful conditional store clears every other requester's reservation on that address.
- R8: A conditional store fails if the issuer has no valid reservation, or if its reservation holds a different address.
- R9: Any conditional store clears the issuer's own reservation, whether it succeeds or fails.
- R10: A new linked load replaces the issuer's earlier reservation.
- R11: A reservation survives three kinds of access: the owner's own plain stores, stores by others to other addresses, and accesses that do not write.
- R12: `rspScOk` is high only in the response to a conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqId | input | $clog2(NUM_REQ) | Issuing requester |
| reqOp | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspData | output | DATA_W | Read data for op 0 and op 2, else zero |
| rspScOk | output | 1 | Conditional store succeeded |

## Verification
Every result is due exactly one clock after its request. A reservation change takes effect for the request in the very next cycle. The bench drives each request on a falling edge and samples the response on the following falling edge, half a period after the register that produces it. Its model updates memory and reservations once per request in the same order. A back-to-back sequence of linked load, intervening access and conditional store therefore checks same-cycle-following hazards with no idle cycles in between.

// File: rtl/linked_store_pkg.sv
package linked_store_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } reqOp_e;

  // strobes from control to datapath for the current request
  typedef struct packed {
    logic valid;
    logic memWrite;
    logic isRead;
    logic condOk;
  } ctrlStrobes_t;

endpackage

// File: rtl/linked_store_ctrl.sv
module linked_store_ctrl
  import linked_store_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  reqOp_e            reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output ctrlStrobes_t      strobes
);

  logic [NUM_REQ-1:0] resvValid;
  logic [ADDR_W-1:0]  resvAddr [NUM_REQ];
  logic               ownHit;
  logic               condPass;

  assign ownHit   = resvValid[reqId] && (resvAddr[reqId] == reqAddr);
  assign condPass = reqValid && (reqOp == OP_COND) && ownHit;

  always_comb begin
    strobes.valid    = reqValid;
    strobes.memWrite = reqValid && ((reqOp == OP_STORE) || condPass);
    strobes.isRead   = reqValid && ((reqOp == OP_LOAD) || (reqOp == OP_LINK));
    strobes.condOk   = condPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= '0;
      for (int i = 0; i < NUM_REQ; i++) resvAddr[i] <= '0;
    end else if (reqValid) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        if (reqId == ID_W'(i)) begin
          if (reqOp == OP_LINK) begin
            resvValid[i] <= 1'b1;
            resvAddr[i]  <= reqAddr;
          end else if (reqOp == OP_COND) begin
            resvValid[i] <= 1'b0;
          end
        end else if (strobes.memWrite && resvAddr[i] == reqAddr) begin
          resvValid[i] <= 1'b0;
        end
      end
    end
  end

  // R10: linked load arms issuer with the new address
  assert_link_arms_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_LINK) |=>
      (resvValid[$past(reqId)] && resvAddr[$past(reqId)] == $past(reqAddr)));

  // R9: any conditional store disarms issuer
  assert_cond_disarms_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_COND) |=> !resvValid[$past(reqId)]);

  // R8: no write from a conditional store without a matching reservation
  assert_cond_needs_resv_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_COND && !resvValid[reqId]) |-> !strobes.memWrite);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_clearChk
    // R6 / R7: a write by another requester to a reserved address disarms it
    assert_foreign_write_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.memWrite && reqId != ID_W'(g) && resvValid[g] && resvAddr[g] == reqAddr)
        |=> !resvValid[g]);
  end

endmodule

// File: rtl/linked_store_datapath.sv
module linked_store_datapath
  import linked_store_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspScOk
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      rspScOk  <= 1'b0;
    end else begin
      if (strobes.memWrite) mem[reqAddr] <= reqWdata;
      rspValid <= strobes.valid;
      rspData  <= strobes.isRead ? mem[reqAddr] : '0;
      rspScOk  <= strobes.condOk;
    end
  end

  // R12: success flag only accompanies a response
  assert_scok_with_rsp_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspScOk |-> rspValid);

  // R2: a response follows exactly one request cycle
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.valid |=> rspValid);

  // R5: success flag never raised without a memory write
  assert_ok_implies_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.condOk |-> strobes.memWrite);

endmodule

// File: rtl/linked_store_monitor.sv
module linked_store_monitor
  import linked_store_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspScOk
);

  ctrlStrobes_t strobes;

  linked_store_ctrl #(
    .NUM_REQ(NUM_REQ),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqId   (reqId),
    .reqOp   (reqOp_e'(reqOp)),
    .reqAddr (reqAddr),
    .strobes (strobes)
  );

  linked_store_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rspValid(rspValid),
    .rspData (rspData),
    .rspScOk (rspScOk)
  );

endmodule

// File: tb/linked_store_monitor_tb.sv
module linked_store_monitor_tb;

  localparam int NR = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqId = '0;
  logic [1:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspValid;
  logic [DW-1:0] rspData;
  logic          rspScOk;

  int checks = 0;
  int fails = 0;

  // bench model
  logic          mRv [NR];
  logic [AW-1:0] mRa [NR];
  logic [DW-1:0] mMem [DEPTH];

  always #10 clk = ~clk;

  linked_store_monitor #(.NUM_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .rspScOk(rspScOk)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic doOp(input int id, input int op, input int addr, input int data,
                      input string tag);
    logic [DW-1:0] expData;
    logic          expOk;
    expData = (op == 0 || op == 2) ? mMem[addr] : '0;
    expOk   = (op == 3) && mRv[id] && (mRa[id] == AW'(addr));
    if (op == 1 || expOk) begin
      mMem[addr] = DW'(data);
      for (int i = 0; i < NR; i++)
        if (i != id && mRa[i] == AW'(addr)) mRv[i] = 1'b0;
    end
    if (op == 2) begin mRv[id] = 1'b1; mRa[id] = AW'(addr); end
    if (op == 3) mRv[id] = 1'b0;
    reqValid = 1'b1; reqId = 2'(id); reqOp = 2'(op);
    reqAddr = AW'(addr); reqWdata = DW'(data);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " rspValid"}, 32'(rspValid), 32'd1);
    check({tag, " rspData"}, 32'(rspData), 32'(expData));
    check({tag, " rspScOk"}, 32'(rspScOk), 32'(expOk));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mRv[i] = 1'b0; mRa[i] = '0; end
    for (int a = 0; a < DEPTH; a++) mMem[a] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 rspValid after reset", 32'(rspValid), 32'd0);
    // R1: memory zero, no reservation valid
    for (int a = 0; a < DEPTH; a++) doOp(a % NR, 0, a, 0, "R1 load after reset");
    for (int i = 0; i < NR; i++) doOp(i, 3, 5, 8'h11, "R1 cond without link");

    // R2 / R3
    doOp(0, 1, 3, 8'hA5, "R3 store");
    doOp(1, 0, 3, 0, "R2 load returns store");
    doOp(2, 2, 3, 0, "R2 link returns data");
    // R4
    doOp(2, 3, 3, 8'h5A, "R4 cond success");
    doOp(0, 0, 3, 0, "R4 value written");
    // R9: second cond fails
    doOp(2, 3, 3, 8'h77, "R9 second cond fails");
    doOp(0, 0, 3, 0, "R5 memory kept");
    // R8: reservation on other address
    doOp(1, 2, 4, 0, "R8 link addr4");
    doOp(1, 3, 5, 8'h66, "R8 cond other addr");
    doOp(1, 3, 4, 8'h66, "R9 after failed cond");
    doOp(0, 0, 5, 0, "R5 addr5 unchanged");
    // R10
    doOp(3, 2, 6, 0, "R10 link 6");
    doOp(3, 2, 7, 0, "R10 link 7");
    doOp(3, 3, 6, 8'h12, "R10 old address fails");
    doOp(3, 2, 6, 0, "R10 relink 6");
    doOp(3, 2, 7, 0, "R10 relink 7");
    doOp(3, 3, 7, 8'h34, "R10 new address succeeds");
    // R7: successful cond clears others
    doOp(0, 2, 8, 0, "R7 link a");
    doOp(1, 2, 8, 0, "R7 link b");
    doOp(0, 3, 8, 8'h9C, "R7 first cond");
    doOp(1, 3, 8, 8'h9D, "R7 loser cond");
    // R11: own store keeps reservation
    doOp(2, 2, 9, 0, "R11 link");
    doOp(2, 1, 9, 8'h44, "R11 own store");
    doOp(2, 3, 9, 8'h45, "R11 cond after own store");

    // sweep: a links X, b does op to X or Y, a conditionally stores X, then load
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int same = 0; same < 2; same++)
          for (int op = 0; op < 4; op++) begin
            int x;
            int y;
            x = (a * 4 + b + op) % DEPTH;
            y = same != 0 ? x : (x + 1) % DEPTH;
            doOp(a, 2, x, 0, "R6 sweep link");
            doOp(b, op, y, (a * 37 + b * 11 + op) & 8'hFF, "R6 sweep intervene");
            doOp(a, 3, x, (a * 13 + b * 7 + same) & 8'hFF, "R6 sweep cond R12");
            doOp(b, 0, x, 0, "R6 sweep readback");
          end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule